// File: doc/BRIEF.md
# Four-Channel Byte-Steered DAC Code Register Bank

This block is the parallel-bus write side of a four-channel, 14-bit digital-to-analog converter. Each channel has two storage stages. The first is an input register that the bus writes. The second is a latch whose value drives the channel's output code.

A bus write happens on a rising clock edge where both `bus_sel` and `bus_wr` are high. A width-select input picks one of two write forms:
- **Word write** (`word_mode` high): the whole 14-bit value is taken from `wdata[13:0]`. A byte-wide host ties `wdata[13:8]` low and uses this form to deliver its low byte.
- **Upper write** (`word_mode` low): the six most significant bits arrive on `wdata[5:0]`.

Two address bits pick the channel. A broadcast bit sends the same write to all four input registers at once. A load strobe copies every input register into its latch on the same edge.

A small display state machine decides whether the outputs show the latches or a fixed clear level. It has three states:
- `ST_LIVE`: outputs show the latches.
- `ST_CLR_HOLD`: clear is asserted.
- `ST_CLR_WAIT`: clear has been released but no load has arrived yet.

The transitions are:
- `ST_LIVE`→`ST_CLR_HOLD` on clear.
- `ST_CLR_HOLD` stays put while clear is high.
- `ST_CLR_HOLD`→`ST_CLR_WAIT` when clear falls with no load.
- `ST_CLR_HOLD`→`ST_LIVE` when clear is low and load is high.
- `ST_CLR_WAIT`→`ST_CLR_HOLD` on clear.
- `ST_CLR_WAIT`→`ST_LIVE` on load without clear.
- `ST_CLR_WAIT` otherwise stays.

A per-channel valid output tells downstream logic which source each output is showing. Output codes are straight binary: 0 is the bottom of the range and 14'h3FFF is full scale minus one LSB.

Top module: `dacbank_top`

## Requirements
- R1: After reset all input registers and latches hold 0, the display state is `ST_LIVE`, every `code_valid` bit is 1 and every output code is 0.
- R2: On an edge with `bus_sel`=1, `bus_wr`=1 and `word_mode`=1, the addressed input register takes `wdata[13:0]`, bit 13 being the MSB.
- R3: On an edge with `bus_sel`=1, `bus_wr`=1 and `word_mode`=0, bits 13:8 of the addressed input register take `wdata[5:0]` (`wdata[5]` to bit 13). Bits 7:0 keep their value, and `wdata[13:6]` has no effect.
- R4: With `bcast`=0, `chan_addr` value n (0..3) selects channel n, and no other channel's register changes. No register changes on an edge where `bus_sel` or `bus_wr` is 0.
- R5: A write with `bcast`=1 updates all four input registers on the same edge, whatever `chan_addr` holds.
- R6: Input register writes do not reach the outputs until a load. An edge with `load`=1 copies all four input registers into their latches. If a write and a load share an edge, the latch takes the value the input register held before that edge.
- R7: From the cycle after an edge with `clear`=1, every output code is `CLR_LEVEL` and every `code_valid` bit is 0. This holds after clear is released, up to an edge with `load`=1 and `clear`=0. From the cycle after that edge, the outputs show their latches with `code_valid`=1.
- R8: A load on an edge where `clear` is 1 still updates the latches, but the outputs stay at `CLR_LEVEL` until a later load with clear low.
- R9: Output codes are the latch values in straight binary. 14'h0000 and 14'h3FFF appear unchanged on `dac_code` when the display is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus select, active high |
| bus_wr | input | 1 | Write enable, active high |
| word_mode | input | 1 | 1: full 14-bit word write; 0: upper six bits from `wdata[5:0]` |
| bcast | input | 1 | 1: the write goes to all channels |
| chan_addr | input | 2 | Channel number when `bcast` is 0 |
| wdata | input | 14 | Write data |
| load | input | 1 | Copies the input registers into the latches |
| clear | input | 1 | Forces outputs to the clear level until the next load |
| dac_code | output | 56 | Output codes; channel n occupies bits 14n+13:14n |
| code_valid | output | 4 | Per channel: 1 when the output shows its latch, 0 when it shows the clear level |

## Verification
A corrupted input register stays hidden until the next load. From the cycle after that load, the wrong code appears on that channel's slice of `dac_code`. The bench therefore loads after every write sweep, so each register error surfaces within two cycles of the write that caused it.

A wrong display state shows at once on `code_valid` and on all four code slices together. The same holds for a missed or extra transition between the two clear states and `ST_LIVE`, visible in the first cycle after the faulty edge. A half write that disturbs the low byte shows only after the load that follows it.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
    typedef enum logic [1:0] {
        ST_LIVE     = 2'd0,
        ST_CLR_HOLD = 2'd1,
        ST_CLR_WAIT = 2'd2
    } disp_state_t;
endpackage

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
    parameter int DW    = 14,
    parameter int LOW_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          word_mode,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output logic [DW-1:0] latch_q
);
    localparam int HIGH_W = DW - LOW_W;

    logic [DW-1:0] inreg_q;

    // Input register: word write or upper-part write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inreg_q <= '0;
        end else if (wr_hit) begin
            if (word_mode) begin
                inreg_q <= wdata;
            end else begin
                inreg_q[DW-1:LOW_W] <= wdata[HIGH_W-1:0];
            end
        end
    end

    // Latch stage: loaded from the pre-edge input register value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= inreg_q;
        end
    end

    AST_HALF_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !word_mode) |=> (inreg_q[LOW_W-1:0] == $past(inreg_q[LOW_W-1:0]))); // R3
    AST_HALF_TAKES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !word_mode) |=> (inreg_q[DW-1:LOW_W] == $past(wdata[HIGH_W-1:0]))); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(inreg_q)); // R4
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (latch_q == $past(inreg_q))); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(latch_q)); // R6
endmodule

// File: rtl/dacbank_disp.sv
module dacbank_disp
    import dacbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    output logic show_latch
);
    disp_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIVE:     state_d = clear ? ST_CLR_HOLD : ST_LIVE;
            ST_CLR_HOLD: state_d = clear ? ST_CLR_HOLD : (load ? ST_LIVE : ST_CLR_WAIT);
            ST_CLR_WAIT: state_d = clear ? ST_CLR_HOLD : (load ? ST_LIVE : ST_CLR_WAIT);
            default:     state_d = ST_LIVE;
        endcase
    end

    // Outputs
    always_comb begin
        show_latch = 1'b0;
        unique case (state_q)
            ST_LIVE:     show_latch = 1'b1;
            ST_CLR_HOLD: show_latch = 1'b0;
            ST_CLR_WAIT: show_latch = 1'b0;
            default:     show_latch = 1'b0;
        endcase
    end

    AST_CLEAR_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == ST_CLR_HOLD)); // R7
    AST_LOAD_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> show_latch); // R7
    AST_NO_LOAD_STAYS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_latch && !load) |=> !show_latch); // R7
    AST_CLEAR_LOAD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && load) |=> !show_latch); // R8
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top #(
    parameter int          DW        = 14,
    parameter int          NCH       = 4,
    parameter int          LOW_W     = 8,
    parameter logic [13:0] CLR_LEVEL = 14'h1555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              word_mode,
    input  logic              bcast,
    input  logic [1:0]        chan_addr,
    input  logic [13:0]       wdata,
    input  logic              load,
    input  logic              clear,
    output logic [55:0]       dac_code,
    output logic [3:0]        code_valid
);
    localparam int AW = $clog2(NCH);

    logic           wr_go;
    logic [NCH-1:0] hit;
    logic           show_latch;

    assign wr_go = bus_sel && bus_wr;

    dacbank_disp u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .load       (load),
        .show_latch (show_latch)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [DW-1:0] latch_q;

        assign hit[i] = wr_go && (bcast || (chan_addr == AW'(i)));

        dacbank_chan #(.DW(DW), .LOW_W(LOW_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (hit[i]),
            .word_mode (word_mode),
            .wdata     (wdata),
            .load      (load),
            .latch_q   (latch_q)
        );

        assign dac_code[i*DW +: DW] = show_latch ? latch_q : CLR_LEVEL;
        assign code_valid[i]        = show_latch;
    end

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !bcast) |-> ($countones(hit) == 1)); // R4
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |-> (hit == '0)); // R4
    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bcast) |-> (&hit)); // R5
    AST_VALID_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_valid == '0) || (&code_valid))); // R7
endmodule

// File: tb/sim_dacbank_top.sv
module sim_dacbank_top;
    localparam logic [13:0] CLR = 14'h1555;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, word_mode = 1'b1, bcast = 1'b0;
    logic [1:0]  chan_addr = '0;
    logic [13:0] wdata = '0;
    logic        load = 1'b0, clear = 1'b0;
    logic [55:0] dac_code;
    logic [3:0]  code_valid;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [13:0] exp_in [4];
    logic [13:0] exp_lat [4];
    bit          exp_live;

    always #2.5 clk = ~clk;

    dacbank_top #(.CLR_LEVEL(CLR)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .word_mode(word_mode), .bcast(bcast), .chan_addr(chan_addr),
        .wdata(wdata), .load(load), .clear(clear),
        .dac_code(dac_code), .code_valid(code_valid)
    );

    task automatic step();
        @(posedge clk);
        for (int i = 0; i < 4; i++) if (load) exp_lat[i] = exp_in[i];
        if (bus_sel && bus_wr)
            for (int i = 0; i < 4; i++)
                if (bcast || chan_addr == 2'(i)) begin
                    if (word_mode) exp_in[i] = wdata;
                    else exp_in[i] = {wdata[5:0], exp_in[i][7:0]};
                end
        if (clear) exp_live = 1'b0;
        else if (load) exp_live = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; load = 1'b0; clear = 1'b0; bcast = 1'b0;
    endtask

    task automatic check(string tag);
        for (int i = 0; i < 4; i++) begin
            logic [13:0] e;
            e = exp_live ? exp_lat[i] : CLR;
            vectors++;
            if (dac_code[i*14 +: 14] !== e || code_valid[i] !== exp_live) begin
                errors++;
                $display("FAIL %s ch%0d: code=%h valid=%b expected code=%h valid=%b",
                         tag, i, dac_code[i*14 +: 14], code_valid[i], e, exp_live);
            end
        end
    endtask

    task automatic wr(bit b, logic [1:0] a, bit wm, logic [13:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bcast = b; chan_addr = a; word_mode = wm; wdata = d;
        step();
    endtask

    task automatic ld();
        load = 1'b1;
        step();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin exp_in[i] = '0; exp_lat[i] = '0; end
        exp_live = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset");

        // R2/R9 word writes per channel, then load
        for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 10; k++) begin
                logic [13:0] d;
                d = (k == 0) ? 14'h0000 : (k == 1) ? 14'h3FFF : 14'(k * 5147 + ch * 977);
                wr(1'b0, 2'(ch), 1'b1, d);
                check("R6 write without load");
                ld();
                check(k < 2 ? "R9 boundary code" : "R2 word write");
            end
        end

        // R4 gating: select or write enable low
        bus_sel = 1'b1; bus_wr = 1'b0; word_mode = 1'b1; wdata = 14'h2AAA; chan_addr = 2'd1;
        step();
        bus_sel = 1'b0; bus_wr = 1'b1; wdata = 14'h2AAA; chan_addr = 2'd2;
        step();
        ld();
        check("R4 gated write");

        // R3 upper writes: sweep all six-bit values with junk on lines 13:6
        for (int ch = 0; ch < 4; ch++) begin
            wr(1'b0, 2'(ch), 1'b1, 14'(8'hA5 + ch));
            for (int v = 0; v < 64; v++) begin
                wr(1'b0, 2'(ch), 1'b0, {8'(v * 37 + 11), 6'(v)});
                ld();
                check("R3 upper write");
            end
        end

        // R5 broadcast word and upper writes
        wr(1'b1, 2'd2, 1'b1, 14'h1234);
        ld();
        check("R5 broadcast word");
        wr(1'b1, 2'd0, 1'b0, 14'h3FEA);
        ld();
        check("R5 broadcast upper");

        // R6 write and load on the same edge
        bus_sel = 1'b1; bus_wr = 1'b1; word_mode = 1'b1; chan_addr = 2'd3; wdata = 14'h0F0F;
        load = 1'b1;
        step();
        check("R6 same-edge load");
        ld();
        check("R6 follow-up load");

        // R7 clear and hold after release
        clear = 1'b1;
        step();
        check("R7 clear asserted");
        for (int c = 0; c < 3; c++) begin clear = 1'b1; step(); end
        check("R7 clear held");
        for (int c = 0; c < 4; c++) step();
        check("R7 after release");
        wr(1'b0, 2'd0, 1'b1, 14'h3001);
        check("R7 write while cleared");
        ld();
        check("R7 load restores");

        // R8 load during clear updates latches but stays cleared
        wr(1'b0, 2'd1, 1'b1, 14'h2468);
        clear = 1'b1; load = 1'b1;
        step();
        check("R8 clear with load");
        step();
        check("R8 released no load");
        clear = 1'b1;
        step();
        load = 1'b1;
        step();
        check("R7 load as clear falls");
        wr(1'b0, 2'd2, 1'b1, 14'h3FFF);
        ld();
        check("R9 full scale");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule